// File: doc/BRIEF.md
# Byte-Command Probe Bank Controller

This block sits behind a debug-link byte receiver and gives a host two banks of probe bits inside a design. The host sends single-byte opcodes to set an output bank, to read back a snapshot of an input bank, and to ask how wide both banks are. Replies go out on a separate byte stream. Data bytes can take any value, including an opcode value, because a prefix byte marks the next byte as literal data.

Both byte streams use valid/ready handshakes. A byte moves on a rising clock edge where valid and ready are both high. On the transmit side the block holds `tx_data` steady for as long as `tx_valid` is high and `tx_ready` is low. The one exception is an accepted reset opcode, which withdraws a pending reply. On the receive side, `rx_ready` drops while a reply is still being sent. Only the escape prefix and a bare reset opcode get through at that time. The host therefore cannot queue a second command behind a reply that is still in flight. Multi-byte values go least-significant byte first. A bank of W bits takes ceil(W/8) bytes.

Top module: `probe_byte_ctrl`

## Requirements
- R1: After the hardware reset, `probe_out` is zero, `tx_valid` is low and `rx_ready` is high.
- R2: A received 0x55 that is not itself escaped produces no action. The byte after it is treated as literal data, whatever its value.
- R3: Opcode 0xAB sends eight bytes: IN_W as a 32-bit value, least-significant byte first, then OUT_W in the same form.
- R4: Opcode 0xBB is followed by ceil(OUT_W/8) data bytes, least-significant byte first. `probe_out` stays unchanged until the last byte is accepted and then takes the assembled value. Bits above OUT_W are dropped.
- R5: Opcode 0xAA samples every `probe_in` bit on the edge where it is accepted. It returns ceil(IN_W/8) bytes, least-significant first, with the unused upper bits as zero. Later changes on `probe_in` do not affect that reply.
- R6: A bare 0xEE returns the controller to idle from any state. It discards a partly received output value and withdraws a pending reply. `probe_out` keeps its value.
- R7: In idle, an unknown byte or an escaped byte produces no reply and leaves `probe_out` unchanged.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data` does not change and the reply does not advance.
- R9: While a reply is pending, `rx_ready` is low for every byte except the escape prefix and a bare 0xEE.
- R10: While an output value is being loaded, every byte except a bare 0xEE is data. An escaped 0xEE or 0x55 is stored as that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted when high with valid |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit consumer ready |
| tx_data | output | 8 | Transmitted byte |
| probe_in | input | IN_W | Input probe bank |
| probe_out | output | OUT_W | Output probe register |

## Verification
The assertions assume that the host drops `rx_valid` only on a cycle boundary and that nothing on the transmit side reacts to `tx_data` except on a completed handshake. The assertions also assume `probe_in` is synchronous to `clk`, so one edge captures a consistent value. The stimulus drives every input just after a rising edge and samples just after a falling edge. It changes `probe_in` only after the read opcode has been accepted. It lowers a held `rx_valid` without a handshake only in the back-pressure test, where no acceptance is expected.

// File: rtl/probe_byte_pkg.sv
`timescale 1ns/1ps
package probe_byte_pkg;
  localparam logic [7:0] OP_RESET  = 8'hEE;
  localparam logic [7:0] OP_ESC    = 8'h55;
  localparam logic [7:0] OP_WIDTHS = 8'hAB;
  localparam logic [7:0] OP_WRITE  = 8'hBB;
  localparam logic [7:0] OP_READ   = 8'hAA;

  typedef enum logic {ST_IDLE, ST_LOAD} eng_state_e;

  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction
endpackage

// File: rtl/probe_esc_strip.sv
`timescale 1ns/1ps
module probe_esc_strip
  import probe_byte_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tok_valid,
  output logic [7:0] tok_data,
  output logic       tok_lit,
  input  logic       tok_ready
);
  logic esc_pend;
  logic is_prefix;

  assign is_prefix = !esc_pend && (rx_data == OP_ESC);
  assign tok_valid = rx_valid && !is_prefix;
  assign tok_data  = rx_data;
  assign tok_lit   = esc_pend;
  assign rx_ready  = is_prefix ? 1'b1 : tok_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   esc_pend <= 1'b0;
    else if (rx_valid && rx_ready) esc_pend <= is_prefix;
  end

  // R2: an accepted prefix marks the following token as literal
  a_r2_prefix_marks_literal: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !tok_lit && rx_data == OP_ESC) |=> tok_lit);

  // R2: a literal flag never survives past the byte it marks
  a_r2_literal_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready && tok_lit) |=> !tok_lit);
endmodule

// File: rtl/probe_reply_shift.sv
`timescale 1ns/1ps
module probe_reply_shift #(
  parameter int BUF_BYTES = 8,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [BUF_BYTES*8-1:0] load_bytes,
  input  logic [CNT_W-1:0]       load_count,
  input  logic                   abort,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [7:0]             tx_data,
  output logic                   busy
);
  logic [BUF_BYTES*8-1:0] shreg;
  logic [CNT_W-1:0]       left;

  assign tx_valid = (left != '0);
  assign tx_data  = shreg[7:0];
  assign busy     = tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (abort) begin
      left <= '0;
    end else if (load) begin
      shreg <= load_bytes;
      left  <= load_count;
    end else if (tx_valid && tx_ready) begin
      shreg <= shreg >> 8;
      left  <= left - 1'b1;
    end
  end

  // R8: a stalled byte is held unchanged
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !abort && !load) |=> (tx_valid && $stable(tx_data)));

  // R6: abort empties the reply
  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !tx_valid);
endmodule

// File: rtl/probe_cmd_engine.sv
`timescale 1ns/1ps
module probe_cmd_engine
  import probe_byte_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int OUT_W     = 10,
  parameter int BUF_BYTES = 8,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tok_valid,
  input  logic [7:0]             tok_data,
  input  logic                   tok_lit,
  output logic                   tok_ready,
  input  logic [IN_W-1:0]        probe_in,
  input  logic                   busy,
  output logic                   load,
  output logic [BUF_BYTES*8-1:0] load_bytes,
  output logic [CNT_W-1:0]       load_count,
  output logic                   abort,
  output logic [OUT_W-1:0]       probe_out
);
  localparam int IN_BYTES  = bytes_for(IN_W);
  localparam int OUT_BYTES = bytes_for(OUT_W);
  localparam int OUT_BITS  = OUT_BYTES * 8;
  localparam int IDX_W     = (OUT_BYTES > 1) ? $clog2(OUT_BYTES) : 1;

  eng_state_e          state;
  logic [IDX_W-1:0]    idx;
  logic [OUT_BITS-1:0] shadow, next_shadow;
  logic                is_reset, fire, last;

  assign is_reset  = !tok_lit && (tok_data == OP_RESET);
  assign tok_ready = busy ? (tok_valid && is_reset) : 1'b1;
  assign fire      = tok_valid && tok_ready;
  assign last      = (idx == IDX_W'(OUT_BYTES - 1));
  assign abort     = fire && is_reset;

  always_comb begin
    next_shadow = shadow;
    next_shadow[idx*8 +: 8] = tok_data;
  end

  always_comb begin
    load       = 1'b0;
    load_bytes = '0;
    load_count = '0;
    if (fire && state == ST_IDLE && !tok_lit) begin
      case (tok_data)
        OP_WIDTHS: begin
          load             = 1'b1;
          load_bytes[63:0] = {32'(OUT_W), 32'(IN_W)};
          load_count       = CNT_W'(8);
        end
        OP_READ: begin
          load                  = 1'b1;
          load_bytes[IN_W-1:0]  = probe_in;
          load_count            = CNT_W'(IN_BYTES);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      shadow    <= '0;
      probe_out <= '0;
    end else if (fire) begin
      if (is_reset) begin
        state <= ST_IDLE;
        idx   <= '0;
      end else begin
        case (state)
          ST_IDLE: if (!tok_lit && tok_data == OP_WRITE) begin
            state <= ST_LOAD;
            idx   <= '0;
          end
          ST_LOAD: begin
            shadow <= next_shadow;
            if (last) begin
              probe_out <= next_shadow[OUT_W-1:0];
              state     <= ST_IDLE;
              idx       <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4: the output bank moves only on the final data byte of a load
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && !is_reset && state == ST_LOAD && last) |=> $stable(probe_out));

  // R9: while a reply is pending only a bare reset gets through
  a_r9_busy_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire) |-> is_reset);

  // R6: an accepted reset leaves the engine idle with no reply pending
  a_r6_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_reset) |=> (state == ST_IDLE && !busy));

  // R5: a reply is never loaded over one already in flight
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/probe_byte_ctrl.sv
`timescale 1ns/1ps
module probe_byte_ctrl
  import probe_byte_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  input  logic [IN_W-1:0]  probe_in,
  output logic [OUT_W-1:0] probe_out
);
  localparam int IN_BYTES  = bytes_for(IN_W);
  localparam int BUF_BYTES = (IN_BYTES > 8) ? IN_BYTES : 8;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);

  logic                   tok_valid, tok_lit, tok_ready;
  logic [7:0]             tok_data;
  logic                   busy, load, abort;
  logic [BUF_BYTES*8-1:0] load_bytes;
  logic [CNT_W-1:0]       load_count;

  probe_esc_strip u_strip (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tok_valid(tok_valid), .tok_data(tok_data), .tok_lit(tok_lit),
    .tok_ready(tok_ready)
  );

  probe_cmd_engine #(
    .IN_W(IN_W), .OUT_W(OUT_W), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_data(tok_data), .tok_lit(tok_lit),
    .tok_ready(tok_ready), .probe_in(probe_in), .busy(busy),
    .load(load), .load_bytes(load_bytes), .load_count(load_count),
    .abort(abort), .probe_out(probe_out)
  );

  probe_reply_shift #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_reply (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_bytes(load_bytes), .load_count(load_count),
    .abort(abort), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .busy(busy)
  );
endmodule

// File: tb/probe_byte_ctrl_test.sv
`timescale 1ns/1ps
module probe_byte_ctrl_test;
  localparam int IN_W  = 12;
  localparam int OUT_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_valid = 1'b0;
  logic             rx_ready;
  logic [7:0]       rx_data = 8'h00;
  logic             tx_valid;
  logic             tx_ready = 1'b0;
  logic [7:0]       tx_data;
  logic [IN_W-1:0]  probe_in = '0;
  logic [OUT_W-1:0] probe_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  probe_byte_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .probe_in(probe_in), .probe_out(probe_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every transmit handshake
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R7 unexpected reply byte", {24'h0, tx_data}, 32'h0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(tx_data == e, "R3/R5 reply byte", {24'h0, tx_data}, {24'h0, e});
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1;
    rx_data  = b;
    do @(negedge clk); while (!rx_ready);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1;
    tx_ready = v;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !tx_valid) break;
    end
    check(exp_q.size() == 0 && !tx_valid, tag, exp_q.size(), 0);
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(probe_out == '0, "R1 probe_out after reset", 32'(probe_out), 0);
    check(tx_valid == 1'b0, "R1 tx_valid after reset", 32'(tx_valid), 0);
    check(rx_ready == 1'b1, "R1 rx_ready after reset", 32'(rx_ready), 1);

    // R3 width report: IN_W then OUT_W, 32-bit LSB first
    set_ready(1'b1);
    exp_q.push_back(8'(IN_W)); exp_q.push_back(8'h00); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    exp_q.push_back(8'(OUT_W)); exp_q.push_back(8'h00); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
    send(8'hAB);
    drain("R3 width reply complete");

    // R5 snapshot: probe_in changes right after acceptance
    probe_in = 12'hA5C;
    exp_q.push_back(8'h5C); exp_q.push_back(8'h0A);
    send(8'hAA);
    probe_in = 12'h3F0;
    drain("R5 read reply complete");

    // R4 output load, LSB first, update only on last byte
    send(8'hBB);
    send(8'h34);
    @(negedge clk);
    check(probe_out == '0, "R4 unchanged mid-load", 32'(probe_out), 0);
    send(8'h02);
    @(negedge clk);
    check(probe_out == 10'h234, "R4 loaded value", 32'(probe_out), 32'h234);
    send(8'hBB); send(8'hFF); send(8'hFF);
    @(negedge clk);
    check(probe_out == 10'h3FF, "R4 upper bits dropped", 32'(probe_out), 32'h3FF);

    // R10 / R2 escaped command values are data
    send(8'hBB); send(8'h55); send(8'hEE); send(8'h55); send(8'h55);
    @(negedge clk);
    check(probe_out == 10'h1EE, "R10 escaped data stored", 32'(probe_out), 32'h1EE);

    // R6 reset discards partial load and restarts byte count
    send(8'hBB); send(8'h11); send(8'hEE);
    @(negedge clk);
    check(probe_out == 10'h1EE, "R6 output kept after reset cmd", 32'(probe_out), 32'h1EE);
    send(8'hBB); send(8'h22); send(8'h01);
    @(negedge clk);
    check(probe_out == 10'h122, "R6 load restarts after reset cmd", 32'(probe_out), 32'h122);

    // R7 unknown and escaped bytes in idle are ignored
    send(8'h13); send(8'h55); send(8'hAA); send(8'h55); send(8'hBB); send(8'h07);
    idle_cycles(4);
    check(tx_valid == 1'b0, "R7 no reply for ignored bytes", 32'(tx_valid), 0);
    check(probe_out == 10'h122, "R7 output unchanged", 32'(probe_out), 32'h122);

    // R8 back-pressure holds the byte, R9 blocks new commands
    set_ready(1'b0);
    probe_in = 12'h0F1;
    exp_q.push_back(8'hF1); exp_q.push_back(8'h00);
    send(8'hAA);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tx_valid && tx_data == 8'hF1, "R8 stalled byte held", {23'h0, tx_valid, tx_data}, 32'h1F1);
    end
    @(posedge clk); #1;
    rx_valid = 1'b1;
    rx_data  = 8'hBB;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(rx_ready == 1'b0, "R9 command blocked while busy", 32'(rx_ready), 0);
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
    set_ready(1'b1);
    drain("R8 reply resumes after stall");

    // R6 reset withdraws a pending reply
    set_ready(1'b0);
    send(8'hAA);
    send(8'hEE);
    @(negedge clk);
    check(tx_valid == 1'b0, "R6 reply withdrawn", 32'(tx_valid), 0);
    set_ready(1'b1);
    idle_cycles(4);
    check(probe_out == 10'h122, "R6 output kept after abort", 32'(probe_out), 32'h122);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule